// File: doc/BRIEF.md
# Self-Refresh Clock-Stop Sequencer

This block is the low-power control sequencer of a DDR-style memory controller. Configuration bits select one of two low-power states, enable low-power entry and allow the memory clock to be stopped. When entry is requested, the block stalls new traffic and waits until every accepted access has completed. It then issues every postponed refresh and gives a single entry command to the memory. After that it can stop the memory clock, drop the PHY-ready flag and, as the last step, tell the upstream clock logic that the interface and 2x clocks may be removed.

Access requests use a valid/ready handshake. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The block never drops a request: while `req_ready` is low the requester holds `req_valid` and its payload, and the request waits. Completions come back on `acc_done`. All memory commands (refresh, self-refresh enter and exit, power-down enter and exit) are single-cycle strobes. Reset is synchronous and active low.

Top module: `sr_clkstop_seq`

## Requirements
- R1: After reset the block is in its running state. `mclk_en`=1, `phy_ready`=1, `req_ready`=1, `upclk_gate_ok`=0, and no command strobe is high.
- R2: `req_ready` is 0 while `cfg_lp_en`=1, while the block is in any state other than running, and while MAX_OUT accesses are outstanding. A stalled request is neither accepted nor lost.
- R3: Self-refresh and power-down entry strobes are never issued while an access is outstanding or a refresh is backlogged. During entry, the backlogged refreshes are issued one per cycle, after the accesses drain and before the entry strobe.
- R4: The refresh backlog counts `ref_tick` pulses in the running and draining states and saturates at BACKLOG_MAX (default 8). While running, with no request valid and nothing outstanding, a pending refresh is issued. Ticks in any low-power state are ignored.
- R5: At entry, `cfg_pd_sel`=0 produces `cmd_sr_enter` and `cfg_pd_sel`=1 produces `cmd_pd_enter`.
- R6: The memory clock is stopped (`mclk_en`=0) only in self-refresh with `cfg_clkstop_en`=1. `phy_ready` is 0 exactly while the clock is stopped or restarting.
- R7: `upclk_gate_ok` rises only after `phy_ready` has been 0 for a cycle. It is high only while the memory clock is stopped in self-refresh and is never high in power-down.
- R8: Clearing `cfg_lp_en` with the clock stopped restarts the clock. `phy_ready` stays 0 for `cfg_stab_cycles`+1 cycles. `phy_ready` then rises in the same cycle as `cmd_sr_exit`, and traffic resumes on the next cycle.
- R9: Clearing `cfg_clkstop_en` while the clock is stopped and `cfg_lp_en`=1 restarts the clock and raises `phy_ready` after the same wait. No exit strobe is issued and `req_ready` stays 0.
- R10: In power-down the clock keeps running. Clearing `cfg_lp_en` issues `cmd_pd_exit` and returns to running.
- R11: Clearing `cfg_lp_en` before the entry strobe aborts entry with no entry strobe and returns to running.
- R12: At most one command strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lp_en | input | 1 | Request low-power entry (1) or exit (0) |
| cfg_pd_sel | input | 1 | 0 selects self-refresh, 1 selects power-down |
| cfg_clkstop_en | input | 1 | Allow the memory clock to be stopped in self-refresh |
| cfg_stab_cycles | input | STAB_W | Clock stabilization wait on restart |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted when high with valid |
| acc_done | input | 1 | One outstanding access completed |
| ref_tick | input | 1 | Refresh interval elapsed |
| cmd_ref | output | 1 | Refresh command strobe |
| cmd_sr_enter | output | 1 | Self-refresh entry strobe |
| cmd_sr_exit | output | 1 | Self-refresh exit strobe |
| cmd_pd_enter | output | 1 | Power-down entry strobe |
| cmd_pd_exit | output | 1 | Power-down exit strobe |
| mclk_en | output | 1 | Memory clock gate enable |
| phy_ready | output | 1 | PHY-ready status flag |
| upclk_gate_ok | output | 1 | Upstream clocks may be removed |

## Verification
The bench fills the outstanding-access limit and backlogs refreshes while a request is held valid. A design that entered early would issue the entry strobe before the last refresh or completion, and a design that dropped the stalled request would accept it after entry. Saturation is checked by sending twelve ticks and expecting eight refreshes, and ticks sent during self-refresh must not produce refreshes after exit. The wake window is measured with a stabilization count of five and of zero, to catch off-by-one errors in the timer. The bench also checks that power-down never stops the clock or allows gating, that clearing clock-stop alone does not issue an exit strobe, and that aborted entries produce no entry strobe.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_DRAIN,
    ST_SR,
    ST_CKSTOP,
    ST_GATED,
    ST_WAKE,
    ST_SREXIT,
    ST_PD
  } seq_state_e;
endpackage

// File: rtl/sr_ref_backlog.sv
module sr_ref_backlog #(
  parameter int MAX = 8,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         tick,
  input  logic         issue,
  output logic [W-1:0] count,
  output logic         nonzero
);
  localparam logic [W-1:0] MAXV = W'(MAX);

  logic inc;
  assign inc     = tick_en && tick;
  assign nonzero = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case ({inc, issue})
        2'b10:   if (count != MAXV) count <= count + 1'b1;
        2'b01:   if (count != '0)   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_backlog_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= MAXV);
  assert_backlog_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV && !issue) |=> count == MAXV);
endmodule

// File: rtl/sr_access_tracker.sv
module sr_access_tracker #(
  parameter int MAX_OUT = 4,
  parameter int W       = $clog2(MAX_OUT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         done,
  output logic [W-1:0] count,
  output logic         empty,
  output logic         full
);
  localparam logic [W-1:0] MAXV = W'(MAX_OUT);

  logic dec;
  assign empty = (count == '0);
  assign full  = (count == MAXV);
  assign dec   = done && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (accept && !dec) begin
      count <= count + 1'b1;
    end else if (dec && !accept) begin
      count <= count - 1'b1;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !accept);
endmodule

// File: rtl/sr_stab_timer.sv
module sr_stab_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sr_clkstop_seq.sv
module sr_clkstop_seq
  import sr_seq_pkg::*;
#(
  parameter int MAX_OUT     = 4,
  parameter int BACKLOG_MAX = 8,
  parameter int STAB_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lp_en,
  input  logic              cfg_pd_sel,
  input  logic              cfg_clkstop_en,
  input  logic [STAB_W-1:0] cfg_stab_cycles,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              acc_done,
  input  logic              ref_tick,
  output logic              cmd_ref,
  output logic              cmd_sr_enter,
  output logic              cmd_sr_exit,
  output logic              cmd_pd_enter,
  output logic              cmd_pd_exit,
  output logic              mclk_en,
  output logic              phy_ready,
  output logic              upclk_gate_ok
);
  localparam int OUT_W = $clog2(MAX_OUT + 1);
  localparam int BL_W  = $clog2(BACKLOG_MAX + 1);

  seq_state_e state, state_nx;

  logic [OUT_W-1:0] out_cnt;
  logic [BL_W-1:0]  bl_cnt;
  logic out_empty, out_full, bl_nz, drained;
  logic accept, tick_en, clk_off, wake_start, stab_done;

  // traffic stall and refresh issue
  assign req_ready = (state == ST_RUN) && !cfg_lp_en && !out_full;
  assign accept    = req_valid && req_ready;
  assign tick_en   = (state == ST_RUN) || (state == ST_DRAIN);
  assign drained   = out_empty && !bl_nz;
  assign cmd_ref   = bl_nz && out_empty &&
                     (((state == ST_RUN) && !cfg_lp_en && !req_valid) ||
                      ((state == ST_DRAIN) && cfg_lp_en));

  // entry and exit strobes
  assign cmd_sr_enter = (state == ST_DRAIN) && cfg_lp_en && drained && !cfg_pd_sel;
  assign cmd_pd_enter = (state == ST_DRAIN) && cfg_lp_en && drained &&  cfg_pd_sel;
  assign cmd_pd_exit  = (state == ST_PD) && !cfg_lp_en;
  assign cmd_sr_exit  = (state == ST_SREXIT);

  // clock and status
  assign clk_off       = (state == ST_CKSTOP) || (state == ST_GATED);
  assign mclk_en       = !clk_off;
  assign phy_ready     = !clk_off && (state != ST_WAKE);
  assign upclk_gate_ok = (state == ST_GATED);
  assign wake_start    = clk_off && (!cfg_lp_en || !cfg_clkstop_en);

  sr_access_tracker #(.MAX_OUT(MAX_OUT), .W(OUT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done(acc_done),
    .count(out_cnt), .empty(out_empty), .full(out_full)
  );

  sr_ref_backlog #(.MAX(BACKLOG_MAX), .W(BL_W)) u_bl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick(ref_tick),
    .issue(cmd_ref), .count(bl_cnt), .nonzero(bl_nz)
  );

  sr_stab_timer #(.W(STAB_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(wake_start), .len(cfg_stab_cycles),
    .done(stab_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:    if (cfg_lp_en) state_nx = ST_DRAIN;
      ST_DRAIN:  if (!cfg_lp_en)   state_nx = ST_RUN;
                 else if (drained) state_nx = cfg_pd_sel ? ST_PD : ST_SR;
      ST_SR:     if (!cfg_lp_en)          state_nx = ST_SREXIT;
                 else if (cfg_clkstop_en) state_nx = ST_CKSTOP;
      ST_CKSTOP,
      ST_GATED:  state_nx = wake_start ? ST_WAKE : ST_GATED;
      ST_WAKE:   if (stab_done) state_nx = cfg_lp_en ? ST_SR : ST_SREXIT;
      ST_SREXIT: state_nx = ST_RUN;
      ST_PD:     if (!cfg_lp_en) state_nx = ST_RUN;
      default:   state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nx;
  end

  assert_stall_outside_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> !req_ready);
  assert_entry_drained_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sr_enter || cmd_pd_enter) |-> (out_cnt == '0 && bl_cnt == '0));
  assert_clock_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en |-> !phy_ready);
  assert_gate_after_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upclk_gate_ok) |-> ($past(!phy_ready) && !mclk_en));
  assert_no_gate_in_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD) |-> (!upclk_gate_ok && mclk_en));
  assert_exit_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sr_exit |-> phy_ready);
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_ref, cmd_sr_enter, cmd_sr_exit, cmd_pd_enter, cmd_pd_exit}) <= 1);
endmodule

// File: tb/sim_sr_clkstop_seq.sv
`timescale 1ns/1ps
module sim_sr_clkstop_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_lp_en = 0, cfg_pd_sel = 0, cfg_clkstop_en = 0;
  logic [7:0] cfg_stab_cycles = 8'd5;
  logic req_valid = 0, acc_done = 0, ref_tick = 0;
  logic req_ready, cmd_ref, cmd_sr_enter, cmd_sr_exit, cmd_pd_enter, cmd_pd_exit;
  logic mclk_en, phy_ready, upclk_gate_ok;

  int checks = 0, errors = 0;
  logic clr = 0;
  int n_ref, n_sren, n_srex, n_pden, n_pdex, n_wake, n_off, gate_bad, multi, order_bad;

  always #4 clk = ~clk;

  sr_clkstop_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_lp_en(cfg_lp_en), .cfg_pd_sel(cfg_pd_sel),
    .cfg_clkstop_en(cfg_clkstop_en), .cfg_stab_cycles(cfg_stab_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .acc_done(acc_done),
    .ref_tick(ref_tick), .cmd_ref(cmd_ref), .cmd_sr_enter(cmd_sr_enter),
    .cmd_sr_exit(cmd_sr_exit), .cmd_pd_enter(cmd_pd_enter),
    .cmd_pd_exit(cmd_pd_exit), .mclk_en(mclk_en), .phy_ready(phy_ready),
    .upclk_gate_ok(upclk_gate_ok)
  );

  // event monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (clr || !rst_n) begin
      n_ref = 0; n_sren = 0; n_srex = 0; n_pden = 0; n_pdex = 0;
      n_wake = 0; n_off = 0; gate_bad = 0; multi = 0; order_bad = 0;
    end else begin
      if (cmd_ref && (n_sren + n_pden) > 0 && (n_srex + n_pdex) == 0) order_bad++;
      n_ref  += int'(cmd_ref);
      n_sren += int'(cmd_sr_enter);
      n_srex += int'(cmd_sr_exit);
      n_pden += int'(cmd_pd_enter);
      n_pdex += int'(cmd_pd_exit);
      if (mclk_en && !phy_ready) n_wake++;
      if (!mclk_en) n_off++;
      if (upclk_gate_ok && phy_ready) gate_bad++;
      if ((int'(cmd_ref) + int'(cmd_sr_enter) + int'(cmd_sr_exit) +
           int'(cmd_pd_enter) + int'(cmd_pd_exit)) > 1) multi++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic clear_counts();
    clr = 1'b1; @(negedge clk); #1; clr = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic fill_and_tick(input int ticks);
    req_valid = 1; cyc(6);
    chk_eq("R2 full stall", int'(req_ready), 0);
    for (int i = 0; i < ticks; i++) begin
      ref_tick = 1; cyc(1); ref_tick = 0; cyc(1);
    end
  endtask

  task automatic drain_done(input int n);
    for (int i = 0; i < n; i++) begin
      acc_done = 1; cyc(1); acc_done = 0; cyc(1);
    end
  endtask

  task automatic t_reset();
    chk_eq("R1 mclk_en", int'(mclk_en), 1);
    chk_eq("R1 phy_ready", int'(phy_ready), 1);
    chk_eq("R1 req_ready", int'(req_ready), 1);
    chk_eq("R1 gate_ok", int'(upclk_gate_ok), 0);
    chk_eq("R1 strobes", int'(cmd_ref | cmd_sr_enter | cmd_sr_exit | cmd_pd_enter | cmd_pd_exit), 0);
  endtask

  task automatic t_idle_refresh();
    clear_counts();
    for (int i = 0; i < 3; i++) begin
      ref_tick = 1; cyc(1); ref_tick = 0; cyc(3);
    end
    chk_eq("R4 idle refresh", n_ref, 3);
  endtask

  task automatic t_sr_full();
    clear_counts();
    cfg_stab_cycles = 8'd5;
    fill_and_tick(3);
    chk_eq("R4 refresh held by traffic", n_ref, 0);
    cfg_lp_en = 1; cyc(4);
    chk_eq("R3 no refresh before drain", n_ref, 0);
    chk_eq("R3 no entry before drain", n_sren, 0);
    chk_eq("R2 lp stall", int'(req_ready), 0);
    req_valid = 0;
    drain_done(4);
    cyc(10);
    chk_eq("R3 backlog refreshes", n_ref, 3);
    chk_eq("R5 sr enter", n_sren, 1);
    chk_eq("R5 no pd enter", n_pden, 0);
    chk_eq("R3 order", order_bad, 0);
    chk_eq("R6 clock runs without stop enable", int'(mclk_en), 1);
    chk_eq("R6 phy ready in sr", int'(phy_ready), 1);
    cfg_clkstop_en = 1; cyc(4);
    chk_eq("R6 clock stopped", int'(mclk_en), 0);
    chk_eq("R6 phy low", int'(phy_ready), 0);
    chk_eq("R7 gate ok", int'(upclk_gate_ok), 1);
    chk_eq("R7 gate while ready", gate_bad, 0);
    cfg_lp_en = 0; cyc(12);
    chk_eq("R8 wake length", n_wake, 6);
    chk_eq("R8 sr exit", n_srex, 1);
    chk_eq("R8 resumed", int'(req_ready), 1);
    chk_eq("R8 phy ready", int'(phy_ready), 1);
    chk_eq("R8 gate cleared", int'(upclk_gate_ok), 0);
    cfg_clkstop_en = 0;
  endtask

  task automatic t_saturate();
    clear_counts();
    fill_and_tick(12);
    cfg_lp_en = 1; req_valid = 0;
    drain_done(4);
    cyc(16);
    chk_eq("R4 saturated backlog", n_ref, 8);
    chk_eq("R5 sr enter", n_sren, 1);
    for (int i = 0; i < 5; i++) begin
      ref_tick = 1; cyc(1); ref_tick = 0; cyc(1);
    end
    cfg_lp_en = 0; cyc(8);
    chk_eq("R4 ticks ignored in sr", n_ref, 8);
    chk_eq("R8 exit without clock stop", n_srex, 1);
    chk_eq("R6 clock never stopped", n_off, 0);
  endtask

  task automatic t_power_down();
    clear_counts();
    cfg_pd_sel = 1; cfg_clkstop_en = 1; cfg_lp_en = 1; cyc(8);
    chk_eq("R5 pd enter", n_pden, 1);
    chk_eq("R5 no sr enter", n_sren, 0);
    chk_eq("R10 clock kept", n_off, 0);
    chk_eq("R7 no gate in pd", int'(upclk_gate_ok), 0);
    chk_eq("R2 pd stall", int'(req_ready), 0);
    cfg_lp_en = 0; cyc(3);
    chk_eq("R10 pd exit", n_pdex, 1);
    chk_eq("R10 resumed", int'(req_ready), 1);
    cfg_pd_sel = 0; cfg_clkstop_en = 0;
  endtask

  task automatic t_clkstop_toggle();
    clear_counts();
    cfg_stab_cycles = 8'd5;
    cfg_clkstop_en = 1; cfg_lp_en = 1; cyc(6);
    chk_eq("R7 gate ok", int'(upclk_gate_ok), 1);
    cfg_clkstop_en = 0; cyc(12);
    chk_eq("R9 clock back", int'(mclk_en), 1);
    chk_eq("R9 phy back", int'(phy_ready), 1);
    chk_eq("R9 wake length", n_wake, 6);
    chk_eq("R9 no exit strobe", n_srex, 0);
    chk_eq("R9 still stalled", int'(req_ready), 0);
    chk_eq("R9 gate dropped", int'(upclk_gate_ok), 0);
    cfg_lp_en = 0; cyc(4);
    chk_eq("R8 exit", n_srex, 1);
    chk_eq("R8 resumed", int'(req_ready), 1);
  endtask

  task automatic t_stab_zero();
    clear_counts();
    cfg_stab_cycles = 8'd0;
    cfg_clkstop_en = 1; cfg_lp_en = 1; cyc(6);
    cfg_lp_en = 0; cyc(6);
    chk_eq("R8 zero stab wake", n_wake, 1);
    chk_eq("R8 zero stab exit", n_srex, 1);
    cfg_clkstop_en = 0; cfg_stab_cycles = 8'd5;
  endtask

  task automatic t_abort();
    clear_counts();
    req_valid = 1; cyc(2); req_valid = 0;
    cfg_lp_en = 1; cyc(4);
    cfg_lp_en = 0; cyc(3);
    chk_eq("R11 no sr enter", n_sren, 0);
    chk_eq("R11 no pd enter", n_pden, 0);
    chk_eq("R11 resumed", int'(req_ready), 1);
    drain_done(2);
    chk_eq("R12 single strobe", multi, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1; cyc(1);
    t_reset();
    t_idle_refresh();
    t_sr_full();
    t_saturate();
    t_power_down();
    t_clkstop_toggle();
    t_stab_zero();
    t_abort();
    chk_eq("R12 single strobe total", multi, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule